// File: doc/BRIEF.md
# Message Bus Command Requester

This block is the initiating end of a narrow, byte-wide register-access bus between two link-layer partners. Local logic hands it one request at a time through a valid/ready port: a read, a write that is only staged at the far end, or a write that commits everything staged so far. The block turns each request into a short burst of bytes on the outbound bus and keeps the bus at the idle code when it has nothing to send.

A second, inbound byte bus carries the far end's answers. The block watches it for a write acknowledge and for a read completion, which is a header byte followed by one data byte. Read data goes back to local logic as a one-cycle pulse. While a read or a committing write waits for its answer, the request port refuses all further traffic. If no answer comes within a set number of cycles, a sticky flag is raised and the port opens again.

Top module: `msgbus_requester`

## Requirements
- R1: After reset the outbound bus is 0x00, `req_ready` is 1, `rsp_valid` is 0 and `timeout_flag` is 0.
- R2: A request accepted on a rising edge is sent starting in the next cycle, one byte per cycle. The first byte has the command nibble in [7:4] and address bits [11:8] in [3:0]. The second byte is address bits [7:0]. Writes add a third byte holding the write data. The `req_kind` value is the command nibble's low two bits: 1 staged write (command 0001), 2 committing write (command 0010), 3 read (command 0011).
- R3: The outbound bus carries 0x00, the idle command, in every cycle in which no request byte is being sent.
- R4: After a staged write, `req_ready` is 1 again in the cycle that shows its last byte, so a following request is sent with no idle cycle between them.
- R5: After a committing write, `req_ready` stays 0 until an inbound byte with upper nibble 0101 (write acknowledge) appears. `req_ready` returns to 1 two cycles after the cycle that carries that byte.
- R6: After a read, `req_ready` stays 0 until an inbound byte with upper nibble 0100 (read completion) is followed by a data byte. In the cycle after the data byte, `rsp_valid` is 1 for exactly one cycle with `rsp_data` equal to that byte, and `req_ready` is 1 in the cycle after that.
- R7: An acknowledge or a completion that does not match the pending request, or that arrives when nothing is pending, has no effect: `rsp_valid` stays 0 and `req_ready` keeps its value.
- R8: If the answer to a read or a committing write has not arrived `TIMEOUT_CYCLES` cycles after the cycle of the request's last byte, `timeout_flag` is set and `req_ready` returns to 1 in that cycle. The flag then stays set until reset.
- R9: A request with `req_kind` 0 is accepted and sends nothing: the outbound bus stays 0x00 and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 none, 1 staged write, 2 committing write, 3 read |
| req_addr | input | 12 | Register address at the far end |
| req_wdata | input | 8 | Write data |
| tx_bus | output | 8 | Outbound message bytes |
| rx_bus | input | 8 | Inbound message bytes |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 8 | Read data |
| timeout_flag | output | 1 | Sticky flag for an answer that never arrived |

## Verification
On every cycle, the assertions check the header byte that follows each accepted request, the closed port after a read or committing write, the single-cycle width of the read pulse, the silence after a kind-0 request and the stickiness of the timeout flag. Only the bench's scenarios can show the byte order of the second and third bytes, the exact cycle at which the port reopens after an acknowledge, completion or expiry, and the fact that a mismatched or late answer is ignored. These scenarios include random response delays and stray answers.

// File: rtl/msgbus_pkg.sv
package msgbus_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 12;
  localparam int KIND_W  = 2;
  localparam int ADDR_HI = ADDR_W - BYTE_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE     = 4'b0000,
    CMD_WR_STAGE = 4'b0001,
    CMD_WR_FINAL = 4'b0010,
    CMD_RD       = 4'b0011,
    CMD_RD_CPL   = 4'b0100,
    CMD_WR_ACK   = 4'b0101
  } msg_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_ACK = 2'd1,
    ST_WAIT_CPL = 2'd2
  } wait_st_e;
endpackage

// File: rtl/msgbus_rst_sync.sv
module msgbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/msgbus_tx_ser.sv
module msgbus_tx_ser
  import msgbus_pkg::*;
#(
  parameter int MAX_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              with_data,
  output logic [BYTE_W-1:0] tx_bus,
  output logic              busy
);
  localparam int TAIL = MAX_BYTES - 1;
  localparam int REM_W = $clog2(MAX_BYTES);

  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] tail_q [TAIL];
  logic [BYTE_W-1:0] tail_d [TAIL];
  logic [REM_W-1:0]  rem_q, rem_d;
  logic              shift_en;

  assign busy     = (rem_q != '0);
  assign shift_en = load | busy;

  always_comb begin
    tx_d  = '0;
    rem_d = rem_q;
    for (int i = 0; i < TAIL; i++) tail_d[i] = tail_q[i];
    if (load) begin
      tx_d      = {cmd, addr[ADDR_W-1:BYTE_W]};
      tail_d[0] = addr[BYTE_W-1:0];
      tail_d[1] = wdata;
      rem_d     = with_data ? REM_W'(2) : REM_W'(1);
    end else if (busy) begin
      tx_d  = tail_q[0];
      for (int i = 0; i < TAIL - 1; i++) tail_d[i] = tail_q[i+1];
      tail_d[TAIL-1] = '0;
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rem_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rem_q <= rem_d;
    end
  end

  for (genvar g = 0; g < TAIL; g++) begin : g_tail
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tail_q[g] <= '0;
      else if (shift_en) tail_q[g] <= tail_d[g];
    end
  end

  assign tx_bus = tx_q;
endmodule

// File: rtl/msgbus_rx_parse.sv
module msgbus_rx_parse
  import msgbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_bus,
  output logic              ack_pulse,
  output logic              cpl_pulse,
  output logic [BYTE_W-1:0] cpl_data
);
  logic              in_data_q, in_data_d;
  logic              ack_q, ack_d;
  logic              cpl_q, cpl_d;
  logic [BYTE_W-1:0] data_q;
  msg_cmd_e          hdr;

  assign hdr = msg_cmd_e'(rx_bus[BYTE_W-1:BYTE_W-CMD_W]);

  always_comb begin
    ack_d     = !in_data_q && (hdr == CMD_WR_ACK);
    in_data_d = !in_data_q && (hdr == CMD_RD_CPL);
    cpl_d     = in_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data_q <= 1'b0;
      ack_q     <= 1'b0;
      cpl_q     <= 1'b0;
    end else begin
      in_data_q <= in_data_d;
      ack_q     <= ack_d;
      cpl_q     <= cpl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (in_data_q) data_q <= rx_bus;
  end

  assign ack_pulse = ack_q;
  assign cpl_pulse = cpl_q;
  assign cpl_data  = data_q;
endmodule

// File: rtl/msgbus_wait_ctl.sv
module msgbus_wait_ctl
  import msgbus_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [KIND_W-1:0] kind,
  input  logic              ser_busy,
  input  logic              ack_pulse,
  input  logic              cpl_pulse,
  output logic              ready,
  output logic              take_cpl,
  output logic              timeout_flag
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  wait_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_q, to_d;
  logic             counting, expire, answered;

  assign ready    = (st_q == ST_IDLE) && !ser_busy;
  assign take_cpl = (st_q == ST_WAIT_CPL) && cpl_pulse;
  assign answered = ((st_q == ST_WAIT_ACK) && ack_pulse) || take_cpl;
  assign counting = (st_q != ST_IDLE) && !ser_busy;
  assign expire   = counting && (cnt_q == LAST) && !answered;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (accept && kind == KIND_W'(CMD_WR_FINAL)) st_d = ST_WAIT_ACK;
        else if (accept && kind == KIND_W'(CMD_RD))  st_d = ST_WAIT_CPL;
      end
      ST_WAIT_ACK, ST_WAIT_CPL: begin
        if (answered || expire) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    cnt_d = counting ? cnt_q + 1'b1 : '0;
    to_d  = to_q | expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign timeout_flag = to_q;
endmodule

// File: rtl/msgbus_requester.sv
module msgbus_requester
  import msgbus_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [11:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic [7:0]  tx_bus,
  input  logic [7:0]  rx_bus,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        timeout_flag
);
  logic             rst_n_i;
  logic             accept, load, ser_busy;
  logic             ack_pulse, cpl_pulse, take_cpl;
  logic [CMD_W-1:0] cmd;

  msgbus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign accept = req_valid && req_ready;
  assign load   = accept && (req_kind != '0);
  assign cmd    = {{(CMD_W-KIND_W){1'b0}}, req_kind};

  msgbus_tx_ser #(.MAX_BYTES(3)) u_ser (
    .clk(clk), .rst_n(rst_n_i), .load(load), .cmd(cmd),
    .addr(req_addr), .wdata(req_wdata),
    .with_data(req_kind != KIND_W'(CMD_RD)),
    .tx_bus(tx_bus), .busy(ser_busy)
  );

  msgbus_rx_parse u_rx (
    .clk(clk), .rst_n(rst_n_i), .rx_bus(rx_bus),
    .ack_pulse(ack_pulse), .cpl_pulse(cpl_pulse), .cpl_data(rsp_data)
  );

  msgbus_wait_ctl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n_i), .accept(accept), .kind(req_kind),
    .ser_busy(ser_busy), .ack_pulse(ack_pulse), .cpl_pulse(cpl_pulse),
    .ready(req_ready), .take_cpl(take_cpl), .timeout_flag(timeout_flag)
  );

  assign rsp_valid = take_cpl;
endmodule

// File: rtl/msgbus_requester_chk.sv
module msgbus_requester_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_kind,
  input logic [11:0] req_addr,
  input logic [7:0]  tx_bus,
  input logic        rsp_valid,
  input logic        timeout_flag
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind != 2'd0) |=> tx_bus == {2'b00, $past(req_kind), $past(req_addr[11:8])});

  p_commit_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd2) |=> !req_ready);

  p_read_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd3) |=> !req_ready);

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_only_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  p_empty_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd0) |=> (tx_bus == 8'h00 && req_ready));
endmodule

bind msgbus_requester msgbus_requester_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_addr(req_addr), .tx_bus(tx_bus),
  .rsp_valid(rsp_valid), .timeout_flag(timeout_flag)
);

// File: tb/sim_msgbus_requester.sv
`timescale 1ns/1ps
module sim_msgbus_requester;
  localparam int TO = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [11:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  tx_bus;
  logic [7:0]  rx_bus;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        timeout_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  msgbus_requester #(.TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .tx_bus(tx_bus), .rx_bus(rx_bus), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .timeout_flag(timeout_flag)
  );

  function automatic logic [7:0] hdr_byte(input logic [1:0] k, input logic [11:0] a);
    return {2'b00, k, a[11:8]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic present(input logic [1:0] k, input logic [11:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Full transaction; at return the bench sits at a negedge with the block idle.
  task automatic txn(input logic [1:0] k, input logic [11:0] a, input logic [7:0] d,
                     input int dly);
    @(negedge clk);
    present(k, a, d);
    if (k == 2'd0) begin
      chk("R9 bus idle", tx_bus, 8'h00);
      chk("R9 ready", req_ready, 1'b1);
      return;
    end
    chk("R2 byte0", tx_bus, hdr_byte(k, a));
    @(negedge clk);
    chk("R2 byte1", tx_bus, a[7:0]);
    if (k != 2'd3) begin
      @(negedge clk);
      chk("R2 byte2", tx_bus, d);
    end
    if (k == 2'd1) begin
      chk("R4 ready on last byte", req_ready, 1'b1);
      @(negedge clk);
      chk("R3 idle after", tx_bus, 8'h00);
      return;
    end
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R3 idle while waiting", tx_bus, 8'h00);
      chk(k == 2'd2 ? "R5 held" : "R6 held", req_ready, 1'b0);
    end
    if (k == 2'd2) begin
      rx_bus = 8'h50 | 8'($urandom_range(0, 15));
      @(negedge clk); rx_bus = 8'h00;
      chk("R5 held after ack", req_ready, 1'b0);
      @(negedge clk);
      chk("R5 reopen", req_ready, 1'b1);
    end else begin
      rx_bus = 8'h40;
      @(negedge clk); rx_bus = d;
      chk("R6 held", req_ready, 1'b0);
      @(negedge clk); rx_bus = 8'h00;
      chk("R6 rsp_valid", rsp_valid, 1'b1);
      chk("R6 rsp_data", rsp_data, d);
      @(negedge clk);
      chk("R6 pulse end", rsp_valid, 1'b0);
      chk("R6 reopen", req_ready, 1'b1);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    int cnt;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0;
    req_wdata = '0; rx_bus = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx_bus", tx_bus, 8'h00);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 rsp_valid", rsp_valid, 1'b0);
    chk("R1 timeout", timeout_flag, 1'b0);

    // directed: each kind, address/data corners
    txn(2'd1, 12'hFFF, 8'hA5, 0);
    txn(2'd2, 12'h000, 8'h00, 0);
    txn(2'd3, 12'hABC, 8'hFF, 5);
    txn(2'd0, 12'h123, 8'h45, 0);

    // R4: back-to-back staged writes, then committing write
    @(negedge clk);
    present(2'd1, 12'h321, 8'h11);
    @(negedge clk); @(negedge clk);
    chk("R4 ready", req_ready, 1'b1);
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 12'h654; req_wdata = 8'h22;
    @(negedge clk); req_valid = 1'b0;
    chk("R4 no gap", tx_bus, hdr_byte(2'd1, 12'h654));
    @(negedge clk); @(negedge clk);
    @(negedge clk);
    chk("R3 nop between", tx_bus, 8'h00);
    txn(2'd2, 12'h987, 8'h33, 3);

    // R7: stray answers while idle
    rx_bus = 8'h50; @(negedge clk);
    rx_bus = 8'h40; @(negedge clk);
    rx_bus = 8'h77; @(negedge clk);
    rx_bus = 8'h00;
    for (int i = 0; i < 3; i++) begin
      chk("R7 idle no rsp", rsp_valid, 1'b0);
      chk("R7 idle ready", req_ready, 1'b1);
      @(negedge clk);
    end

    // R7: acknowledge while a read is pending is ignored
    present(2'd3, 12'h0F0, 8'h00);
    @(negedge clk);
    rx_bus = 8'h50; @(negedge clk); rx_bus = 8'h00;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 ack ignored", req_ready, 1'b0);
      chk("R7 no rsp", rsp_valid, 1'b0);
    end
    rx_bus = 8'h40; @(negedge clk); rx_bus = 8'h5A; @(negedge clk); rx_bus = 8'h00;
    chk("R6 data after stray", rsp_data, 8'h5A);
    chk("R6 valid after stray", rsp_valid, 1'b1);
    @(negedge clk);

    // R7: completion while a commit is pending is ignored
    present(2'd2, 12'h00F, 8'hC3);
    @(negedge clk); @(negedge clk);
    rx_bus = 8'h40; @(negedge clk); rx_bus = 8'h99; @(negedge clk); rx_bus = 8'h00;
    chk("R7 cpl ignored rsp", rsp_valid, 1'b0);
    @(negedge clk);
    chk("R7 cpl ignored ready", req_ready, 1'b0);
    rx_bus = 8'h50; @(negedge clk); rx_bus = 8'h00; @(negedge clk);
    chk("R5 reopen after stray", req_ready, 1'b1);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      txn(2'($urandom_range(0, 3)), 12'($urandom), 8'($urandom),
          int'($urandom_range(0, 10)));
    end
    chk("R8 no spurious timeout", timeout_flag, 1'b0);

    // R8: read without answer
    @(negedge clk);
    present(2'd3, 12'h777, 8'h00);
    @(negedge clk);
    cnt = 0;
    while (!req_ready && cnt < 200) begin
      @(negedge clk); cnt++;
    end
    chk("R8 expiry cycle", cnt, TO);
    chk("R8 flag set", timeout_flag, 1'b1);
    rx_bus = 8'h40; @(negedge clk); rx_bus = 8'h66; @(negedge clk); rx_bus = 8'h00;
    chk("R7 late cpl ignored", rsp_valid, 1'b0);
    @(negedge clk);
    chk("R7 late cpl ready", req_ready, 1'b1);
    txn(2'd1, 12'h444, 8'h44, 0);
    chk("R8 sticky", timeout_flag, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule